// File: doc/BRIEF.md
# Receive Frame Parser with CRC Check

This block sits behind a demodulator that delivers one detected byte per `byte_valid` strobe. It hunts the byte stream for a run of four `0x00` synchronisation bytes followed by the delimiter `0xA7`. The byte after the delimiter is a length field that frames the rest of the packet. The body that follows is checked against its trailing 16-bit frame check sequence.

A frame is delivered in one of two ways. In packet mode the body is written into an internal buffer, which the host reads through a simple address port. In streaming mode each body byte is handed to the host as a one-byte word with its own strobe. In both modes the end of a frame raises a level interrupt and latches a status word: length, CRC result, length error and overrun. That status holds until the host acknowledges it. A new frame whose length byte arrives while that interrupt is still pending is skipped by its length and flagged as an overrun.

The controller has five states. HUNT counts consecutive sync bytes. SFD expects the delimiter. LEN captures and validates the length. BODY stores or streams the body bytes and checks them. SKIP consumes the body of a discarded frame. The transitions are:

- HUNT→SFD on the fourth consecutive `0x00`.
- SFD→LEN on `0xA7`.
- SFD→HUNT on any other byte.
- LEN→BODY on a valid length with no interrupt pending.
- LEN→SKIP on a valid length while an interrupt is pending.
- LEN→HUNT on an invalid length.
- BODY→HUNT and SKIP→HUNT on the last body byte.

Top module: `rx_frame_parser`

## Requirements
- R1: A frame is recognised only after exactly four consecutive accepted `0x00` bytes followed by the delimiter byte `0xA7`. The next accepted byte is the length L, which counts every body byte, including the two check bytes.
- R2: Two cases send the parser back to hunting, and in both the offending byte is discarded rather than counted as a sync byte. The first is a non-zero byte during the sync run. The second is any byte other than `0xA7` where the delimiter is due.
- R3: A length below 2 or above 127 drops the frame and sets the following status: `stat_len_err`=1, `stat_len`=the received length value, `stat_crc_ok`=0 and `irq_frame`=1. The parser then hunts again.
- R4: The check bytes are CRC-16 with polynomial x^16+x^12+x^5+1, processed LSB first (reflected constant 0x8408), initial value 0 and no final inversion. The CRC is computed over the L-2 payload bytes and sent low byte first. `stat_crc_ok` is 1 exactly when the received check bytes equal the computed value.
- R5: In packet mode, body byte i (0 ≤ i < L, check bytes at L-2 and L-1) is stored at buffer address i. `buf_rd_data` shows the byte at `buf_rd_addr` one cycle after the address is presented.
- R6: One cycle after the last body byte is accepted, in either mode, `irq_frame` is 1 and `stat_len` equals L.
- R7: `irq_frame` and all status outputs hold their values until `host_ack`. One cycle after `host_ack`, all of them read 0.
- R8: A frame whose length byte arrives while `irq_frame` is pending is discarded: its L body bytes are skipped, nothing is written or streamed, `stat_overrun` becomes 1 and the other status fields keep their values.
- R9: In streaming mode, each accepted body byte, including the check bytes, produces `word_valid`=1 for one cycle, one cycle after acceptance, with the byte on `word_data`. The buffer is not written.
- R10: `stream_mode` is sampled when the length byte is accepted. Changing it later has no effect on the current frame.
- R11: After reset, `irq_frame`, `word_valid` and all status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | A detected byte is present on `byte_data` |
| byte_data | input | 8 | Detected byte from the demodulator |
| stream_mode | input | 1 | 1 = streaming delivery, 0 = packet delivery (sampled at the length byte) |
| host_ack | input | 1 | Host acknowledge; clears interrupt and status |
| buf_rd_addr | input | 7 | Buffer read address |
| buf_rd_data | output | 8 | Buffer read data, one cycle after address |
| word_valid | output | 1 | One-cycle strobe for a streamed body byte |
| word_data | output | 8 | Streamed body byte |
| irq_frame | output | 1 | Frame-level interrupt, held until acknowledged |
| stat_len | output | 8 | Received length of the reported frame |
| stat_crc_ok | output | 1 | Check bytes matched |
| stat_len_err | output | 1 | Length field was out of range |
| stat_overrun | output | 1 | A frame was discarded while an interrupt was pending |

## Verification
The hardest situation to reach from the ports is an overrun. A second frame has to start while the first frame's completion is still unacknowledged, and the parser must then skip exactly that frame's body and resume hunting. The stimulus gets there by withholding `host_ack` after a packet-mode frame and sending further complete frames. It then reads back the buffer and status to show they are unchanged, and sends a final frame after acknowledging to show the skip ended on the right byte. Every length from 2 to 127 is swept with a fresh payload and a fully read-back buffer. The near-miss sync patterns are also sent, including a fifth zero where the delimiter is due.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SFD,
        ST_LEN,
        ST_BODY,
        ST_SKIP
    } rx_state_t;

    // One byte through a reflected CRC-16 (x^16+x^12+x^5+1), LSB first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c_in,
                                               input logic [7:0]  d);
        logic [15:0] c;
        c = c_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ d[b]) c = (c >> 1) ^ 16'h8408;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxp_crc16.sv
module rxp_crc16 #(
    parameter logic [15:0] INIT = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc_next
);
    import rxp_pkg::*;

    logic [15:0] crc_q;

    assign crc_next = crc16_byte(crc_q, din);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc_q <= INIT;
        else if (clr) crc_q <= INIT;
        else if (en)  crc_q <= crc_next;
    end

endmodule

// File: rtl/rxp_frame_ram.sv
module rxp_frame_ram #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/rx_frame_parser.sv
module rx_frame_parser #(
    parameter int          PRE_LEN   = 4,
    parameter logic [7:0]  PRE_BYTE  = 8'h00,
    parameter logic [7:0]  SFD_BYTE  = 8'hA7,
    parameter int          MIN_LEN   = 2,
    parameter int          MAX_LEN   = 127,
    parameter int          BUF_DEPTH = 128,
    localparam int         AW        = $clog2(BUF_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    input  logic          stream_mode,
    input  logic          host_ack,
    input  logic [AW-1:0] buf_rd_addr,
    output logic [7:0]    buf_rd_data,
    output logic          word_valid,
    output logic [7:0]    word_data,
    output logic          irq_frame,
    output logic [7:0]    stat_len,
    output logic          stat_crc_ok,
    output logic          stat_len_err,
    output logic          stat_overrun
);
    import rxp_pkg::*;

    localparam int             PCW      = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
    localparam logic [PCW-1:0] PRE_LAST = PCW'(PRE_LEN - 1);
    localparam logic [7:0]     LEN_MIN  = 8'(MIN_LEN);
    localparam logic [7:0]     LEN_MAX  = 8'(MAX_LEN);

    rx_state_t      state_q, state_d;
    logic [PCW-1:0] pre_cnt_q;
    logic [7:0]     len_q;
    logic [7:0]     idx_q;
    logic           stream_q;
    logic           pending_q;

    logic           len_ok;
    logic           last_byte;
    logic           busy;
    logic           is_pre;
    logic [15:0]    crc_next;
    logic           crc_clr;
    logic           crc_en;
    logic           ram_we;

    assign len_ok    = (byte_data >= LEN_MIN) && (byte_data <= LEN_MAX);
    assign last_byte = (idx_q == (len_q - 8'd1));
    assign busy      = pending_q && !host_ack;
    assign is_pre    = (byte_data == PRE_BYTE);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (byte_valid) begin
            unique case (state_q)
                ST_HUNT: if (is_pre && (pre_cnt_q == PRE_LAST)) state_d = ST_SFD;
                ST_SFD:  state_d = (byte_data == SFD_BYTE) ? ST_LEN : ST_HUNT;
                ST_LEN: begin
                    if (!len_ok)   state_d = ST_HUNT;
                    else if (busy) state_d = ST_SKIP;
                    else           state_d = ST_BODY;
                end
                ST_BODY: if (last_byte) state_d = ST_HUNT;
                ST_SKIP: if (last_byte) state_d = ST_HUNT;
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt_q    <= '0;
            len_q        <= '0;
            idx_q        <= '0;
            stream_q     <= 1'b0;
            pending_q    <= 1'b0;
            word_valid   <= 1'b0;
            word_data    <= '0;
            stat_len     <= '0;
            stat_crc_ok  <= 1'b0;
            stat_len_err <= 1'b0;
            stat_overrun <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (host_ack) begin
                pending_q    <= 1'b0;
                stat_len     <= '0;
                stat_crc_ok  <= 1'b0;
                stat_len_err <= 1'b0;
                stat_overrun <= 1'b0;
            end
            if (byte_valid) begin
                unique case (state_q)
                    ST_HUNT: begin
                        if (!is_pre || (pre_cnt_q == PRE_LAST)) pre_cnt_q <= '0;
                        else                                    pre_cnt_q <= pre_cnt_q + 1'b1;
                    end
                    ST_SFD: pre_cnt_q <= '0;
                    ST_LEN: begin
                        len_q    <= byte_data;
                        idx_q    <= '0;
                        stream_q <= stream_mode;
                        if (busy) begin
                            stat_overrun <= 1'b1;
                        end else if (!len_ok) begin
                            pending_q    <= 1'b1;
                            stat_len     <= byte_data;
                            stat_len_err <= 1'b1;
                            stat_crc_ok  <= 1'b0;
                        end
                    end
                    ST_BODY: begin
                        idx_q <= idx_q + 8'd1;
                        if (stream_q) begin
                            word_valid <= 1'b1;
                            word_data  <= byte_data;
                        end
                        if (last_byte) begin
                            pending_q    <= 1'b1;
                            stat_len     <= len_q;
                            stat_crc_ok  <= (crc_next == 16'h0000);
                            stat_len_err <= 1'b0;
                        end
                    end
                    ST_SKIP: idx_q <= idx_q + 8'd1;
                    default: pre_cnt_q <= '0;
                endcase
            end
        end
    end

    assign irq_frame = pending_q;

    // ---------------- check-sequence unit ----------------
    // Running the CRC over the body including the check bytes leaves zero on a match.
    assign crc_clr = byte_valid && (state_q == ST_LEN);
    assign crc_en  = byte_valid && (state_q == ST_BODY);

    rxp_crc16 #(.INIT(16'h0000)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (crc_clr),
        .en       (crc_en),
        .din      (byte_data),
        .crc_next (crc_next)
    );

    // ---------------- receive buffer ----------------
    assign ram_we = byte_valid && (state_q == ST_BODY) && !stream_q;

    rxp_frame_ram #(.DEPTH(BUF_DEPTH), .DW(8)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (idx_q[AW-1:0]),
        .wdata (byte_data),
        .raddr (buf_rd_addr),
        .rdata (buf_rd_data)
    );

endmodule

// File: rtl/rx_frame_parser_chk.sv
module rx_frame_parser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_ack,
    input logic       byte_valid,
    input logic       irq_frame,
    input logic [7:0] stat_len,
    input logic       stat_crc_ok,
    input logic       stat_len_err,
    input logic       stat_overrun,
    input logic       word_valid
);
    // R7: interrupt only drops after an acknowledge
    assert_irq_clear_by_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_frame) |-> $past(host_ack));

    // R7: reported status is frozen while pending and not acknowledged
    assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_frame && !host_ack) |=> ($stable(stat_len) && $stable(stat_crc_ok) && $stable(stat_len_err)));

    // R8: overrun only arises while a completion is pending
    assert_overrun_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_overrun) |-> $past(irq_frame));

    // R9: a streamed word follows an accepted byte
    assert_word_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(byte_valid));

    // R3: a length error never reports a good CRC
    assert_err_excl_crc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_len_err && stat_crc_ok));

    // R6: any reported status comes with the interrupt
    assert_status_with_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_crc_ok || stat_len_err) |-> irq_frame);

endmodule

bind rx_frame_parser rx_frame_parser_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_ack     (host_ack),
    .byte_valid   (byte_valid),
    .irq_frame    (irq_frame),
    .stat_len     (stat_len),
    .stat_crc_ok  (stat_crc_ok),
    .stat_len_err (stat_len_err),
    .stat_overrun (stat_overrun),
    .word_valid   (word_valid)
);

// File: tb/rx_frame_parser_tb.sv
module rx_frame_parser_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       stream_mode;
    logic       host_ack;
    logic [6:0] buf_rd_addr;
    logic [7:0] buf_rd_data;
    logic       word_valid;
    logic [7:0] word_data;
    logic       irq_frame;
    logic [7:0] stat_len;
    logic       stat_crc_ok;
    logic       stat_len_err;
    logic       stat_overrun;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    logic [7:0] body  [0:127];
    logic [7:0] saved [0:127];

    always #10 clk = ~clk;

    rx_frame_parser u_dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .stream_mode(stream_mode), .host_ack(host_ack), .buf_rd_addr(buf_rd_addr),
        .buf_rd_data(buf_rd_data), .word_valid(word_valid), .word_data(word_data),
        .irq_frame(irq_frame), .stat_len(stat_len), .stat_crc_ok(stat_crc_ok),
        .stat_len_err(stat_len_err), .stat_overrun(stat_overrun)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ body[i][b];
                c = {1'b0, c[15:1]};
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    task automatic build(input int len, input int seed);
        logic [15:0] c;
        for (int i = 0; i < len - 2; i++) body[i] = 8'((seed * 7 + i * 13 + 5) ^ 8'h5A);
        c = ref_crc(len - 2);
        body[len-2] = c[7:0];
        body[len-1] = c[15:8];
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic send_head(input logic [7:0] len);
        for (int i = 0; i < 4; i++) send_byte(8'h00);
        send_byte(8'hA7);
        send_byte(len);
    endtask

    task automatic send_frame(input int len, input bit exp_words, input bit flip_mode, input string req);
        send_head(8'(len));
        if (flip_mode) stream_mode = ~stream_mode;
        for (int i = 0; i < len; i++) begin
            send_byte(body[i]);
            check_eq(req, "word_valid", int'(word_valid), int'(exp_words));
            if (exp_words) check_eq(req, "word_data", int'(word_data), int'(body[i]));
        end
    endtask

    task automatic read_buf(input int a, output logic [7:0] d);
        @(negedge clk);
        buf_rd_addr = 7'(a);
        @(negedge clk);
        d = buf_rd_data;
    endtask

    task automatic ack();
        @(negedge clk);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    task automatic check_status(input string req, input int irq, input int len,
                                input int crc, input int lerr, input int ovr);
        check_eq(req, "irq_frame",    int'(irq_frame),    irq);
        check_eq(req, "stat_len",     int'(stat_len),     len);
        check_eq(req, "stat_crc_ok",  int'(stat_crc_ok),  crc);
        check_eq(req, "stat_len_err", int'(stat_len_err), lerr);
        check_eq(req, "stat_overrun", int'(stat_overrun), ovr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int bad_lens[4];
        rst_n = 1'b0; byte_valid = 1'b0; byte_data = '0; stream_mode = 1'b0;
        host_ack = 1'b0; buf_rd_addr = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check_status("R11", 0, 0, 0, 0, 0);
        check_eq("R11", "word_valid", int'(word_valid), 0);
        rst_n = 1'b1;

        // R1 R4 R5 R6 R7: every legal length in packet mode
        for (int len = 2; len <= 127; len++) begin
            build(len, len);
            send_frame(len, 1'b0, 1'b0, "R1");
            check_status("R6", 1, len, 1, 0, 0);
            for (int i = 0; i < len; i++) begin
                read_buf(i, d);
                check_eq("R5", "buf_rd_data", int'(d), int'(body[i]));
            end
            ack();
            check_status("R7", 0, 0, 0, 0, 0);
        end

        // R4 corrupted payload or check bytes
        for (int k = 0; k < 4; k++) begin
            int len = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 60 : 127;
            build(len, 3 + k);
            body[len/2] = body[len/2] ^ 8'h10;
            send_frame(len, 1'b0, 1'b0, "R4");
            check_status("R4", 1, len, 0, 0, 0);
            ack();
        end
        build(40, 9);
        body[39] = body[39] ^ 8'h80;
        send_frame(40, 1'b0, 1'b0, "R4");
        check_status("R4", 1, 40, 0, 0, 0);
        ack();

        // R3 out-of-range length values
        bad_lens = '{0, 1, 128, 255};
        foreach (bad_lens[k]) begin
            send_head(8'(bad_lens[k]));
            check_status("R3", 1, bad_lens[k], 0, 1, 0);
            ack();
            build(5, k);
            send_frame(5, 1'b0, 1'b0, "R3");
            check_status("R3", 1, 5, 1, 0, 0);
            ack();
        end

        // R2 broken sync run: non-zero inside the run, then a lone zero before the delimiter
        build(5, 11);
        for (int i = 0; i < 3; i++) send_byte(8'h00);
        send_byte(8'h01);
        send_byte(8'h00);
        send_byte(8'hA7);
        send_byte(8'd5);
        for (int i = 0; i < 5; i++) send_byte(body[i]);
        check_status("R2", 0, 0, 0, 0, 0);
        // wrong delimiter
        for (int i = 0; i < 4; i++) send_byte(8'h00);
        send_byte(8'hA6);
        send_byte(8'd5);
        for (int i = 0; i < 5; i++) send_byte(body[i]);
        check_status("R2", 0, 0, 0, 0, 0);
        // fifth zero where the delimiter is due: discarded, not reused
        for (int i = 0; i < 5; i++) send_byte(8'h00);
        send_byte(8'hA7);
        send_byte(8'd5);
        for (int i = 0; i < 5; i++) send_byte(body[i]);
        check_status("R2", 0, 0, 0, 0, 0);

        // R8 overrun while pending
        build(10, 21);
        send_frame(10, 1'b0, 1'b0, "R8");
        for (int i = 0; i < 10; i++) saved[i] = body[i];
        build(20, 22);
        send_frame(20, 1'b0, 1'b0, "R8");
        check_status("R8", 1, 10, 1, 0, 1);
        for (int i = 0; i < 10; i++) begin
            read_buf(i, d);
            check_eq("R8", "buf kept", int'(d), int'(saved[i]));
        end
        stream_mode = 1'b1;
        build(8, 23);
        send_frame(8, 1'b0, 1'b0, "R8");
        check_status("R8", 1, 10, 1, 0, 1);
        stream_mode = 1'b0;
        ack();
        check_status("R7", 0, 0, 0, 0, 0);
        build(12, 24);
        send_frame(12, 1'b0, 1'b0, "R8");
        check_status("R8", 1, 12, 1, 0, 0);
        saved[0] = body[0];
        ack();

        // R9 streaming delivery, buffer untouched
        stream_mode = 1'b1;
        build(30, 25);
        send_frame(30, 1'b1, 1'b0, "R9");
        check_status("R9", 1, 30, 1, 0, 0);
        read_buf(0, d);
        check_eq("R9", "buf untouched", int'(d), int'(saved[0]));
        ack();
        build(7, 26);
        body[2] = body[2] ^ 8'h01;
        send_frame(7, 1'b1, 1'b0, "R9");
        check_status("R4", 1, 7, 0, 0, 0);
        ack();

        // R10 mode latched at the length byte
        stream_mode = 1'b0;
        build(16, 27);
        send_frame(16, 1'b0, 1'b1, "R10");
        check_status("R10", 1, 16, 1, 0, 0);
        for (int i = 0; i < 16; i++) begin
            read_buf(i, d);
            check_eq("R10", "buf_rd_data", int'(d), int'(body[i]));
        end
        ack();
        build(9, 28);
        send_frame(9, 1'b1, 1'b1, "R10");
        check_status("R10", 1, 9, 1, 0, 0);
        ack();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule